// File: doc/BRIEF.md
# Cell Voltage Drop Detector

This block watches the voltage of a single charging cell, supplied as a stream of converter codes, and decides when a fast charge has reached its end by voltage. At a slow, fixed interval it requests a burst of conversions from an external converter. The conversions in a burst are evenly spaced, and the block averages them into one sample, which removes mains ripple. The burst is 32 conversions long in peak mode and 16 in delta mode. It then compares each sample with the highest in-window sample seen since the charge cycle began.

Two drop criteria can be selected. Peak mode reacts to a small fall of a few millivolts below the recorded peak. Delta mode waits for a larger fall of about twelve millivolts. Comparisons only count while the cell lies between 1 V and 2 V. They are also suppressed for a programmable hold-off after the start of charge, so that early voltage spikes cannot end the charge. A synchronous clear, pulsed by the charge sequencer at every new charge cycle, empties all history. All timing is counted in pulses of a `tick` input, so the 17-second sample interval and the 57 µs conversion spacing become parameters of the tick period.

Top module: `cell_drop_detector`

## Requirements
- R1: After each INTERVAL_TICKS ticks from clear, a burst starts. In the burst, `conv_req` pulses once per conversion and the pulses are SPACE_TICKS ticks apart. A burst has 32 requests when `mode` is 0 (peak) and 16 when `mode` is 1 (delta).
- R2: `sample_code` is the sum of the burst's conversion codes shifted right by 5 bits in peak mode and by 4 bits in delta mode (a floor mean). Codes are 12-bit unsigned at 0.5 mV per LSB. The mode is taken at the start of the burst.
- R3: `sample_valid` is a one-cycle pulse two clock cycles after the cycle in which the burst's last `conv_valid` is sampled. `sample_code` is valid with it.
- R4: In peak mode, `term` pulses together with `sample_valid` when the recorded peak minus the sample is at least 5 LSB. A drop of 4 LSB gives no pulse.
- R5: In delta mode, `term` pulses when the drop below the recorded peak is at least 24 LSB. A drop of 23 LSB gives no pulse.
- R6: Only samples strictly between code 2000 (1 V) and code 4000 (2 V) are tested or may raise the recorded peak. Samples outside that range do neither.
- R7: While fewer than `holdoff_ticks` ticks have passed since clear, samples neither cause `term` nor raise the recorded peak.
- R8: After `term` has pulsed once, no further pulse occurs until the next clear.
- R9: `clr` forgets the recorded peak, restarts the hold-off count, empties the accumulator and restarts the interval count.
- R10: During and right after reset, `conv_req`, `sample_valid` and `term` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous start-of-charge clear |
| tick | input | 1 | Timebase pulse, one cycle wide |
| mode | input | 1 | 0 = peak mode, 1 = delta mode |
| holdoff_ticks | input | HOLD_W | Hold-off length in ticks |
| conv_req | output | 1 | Conversion request pulse |
| conv_valid | input | 1 | Conversion result strobe |
| conv_code | input | CODE_W | Conversion result |
| sample_valid | output | 1 | Averaged sample strobe |
| sample_code | output | CODE_W | Averaged sample |
| term | output | 1 | Voltage termination pulse |

## Verification
The converter model answers each `conv_req` one cycle later, so the bench knows exactly which codes went into a sample and when the last one was sampled. It expects `sample_valid` and `term` together, two cycles after that last conversion, and it checks both in that cycle. Request spacing is measured between consecutive requests of a burst. That spacing is always twice SPACE_TICKS in cycles, because the bench ticks every other cycle. Hold-off boundaries are placed well away from sample times, so the bench's own tick count decides the hold-off without any off-by-one dependence.

// File: rtl/cdd_pkg.sv
package cdd_pkg;
  typedef enum logic {
    TM_PEAK  = 1'b0,
    TM_DELTA = 1'b1
  } term_mode_e;
endpackage

// File: rtl/cdd_pacer.sv
module cdd_pacer
  import cdd_pkg::*;
#(
  parameter int INTERVAL_TICKS = 298246,
  parameter int SPACE_TICKS    = 1,
  parameter int LOG_N_PEAK     = 5,
  parameter int LOG_N_DELTA    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       tick,
  input  logic       mode,
  output logic       conv_req,
  output term_mode_e burst_mode
);
  localparam int LOG_MAX = (LOG_N_PEAK > LOG_N_DELTA) ? LOG_N_PEAK : LOG_N_DELTA;
  localparam int REQ_W   = LOG_MAX + 1;
  localparam int IV_W    = $clog2(INTERVAL_TICKS + 1);
  localparam int SP_W    = $clog2(SPACE_TICKS + 1);
  localparam logic [IV_W-1:0]  IV_LAST = IV_W'(INTERVAL_TICKS - 1);
  localparam logic [SP_W-1:0]  SP_LAST = SP_W'(SPACE_TICKS - 1);
  localparam logic [REQ_W-1:0] LEFT_P  = REQ_W'((1 << LOG_N_PEAK) - 1);
  localparam logic [REQ_W-1:0] LEFT_D  = REQ_W'((1 << LOG_N_DELTA) - 1);

  logic [IV_W-1:0]  iv_cnt;
  logic [SP_W-1:0]  sp_cnt;
  logic [REQ_W-1:0] req_left;
  logic             busy;
  logic             iv_wrap;

  assign iv_wrap = tick && (iv_cnt == IV_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      iv_cnt     <= '0;
      sp_cnt     <= '0;
      req_left   <= '0;
      busy       <= 1'b0;
      conv_req   <= 1'b0;
      burst_mode <= TM_PEAK;
    end else begin
      conv_req <= 1'b0;
      if (tick) begin
        iv_cnt <= iv_wrap ? '0 : iv_cnt + 1'b1;
      end
      if (iv_wrap && !busy) begin
        busy       <= 1'b1;
        burst_mode <= term_mode_e'(mode);
        conv_req   <= 1'b1;
        req_left   <= mode ? LEFT_D : LEFT_P;
        sp_cnt     <= '0;
      end else if (busy && tick) begin
        if (sp_cnt == SP_LAST) begin
          sp_cnt <= '0;
          if (req_left == '0) begin
            busy <= 1'b0;
          end else begin
            conv_req <= 1'b1;
            req_left <= req_left - 1'b1;
          end
        end else begin
          sp_cnt <= sp_cnt + 1'b1;
        end
      end
    end
  end

  AST_REQ_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> busy); // R1
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(clr) && !$past(rst)) |-> $stable(burst_mode)); // R2
endmodule

// File: rtl/cdd_accum.sv
module cdd_accum
  import cdd_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int LOG_N_PEAK  = 5,
  parameter int LOG_N_DELTA = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              conv_valid,
  input  logic [CODE_W-1:0] conv_code,
  input  term_mode_e        burst_mode,
  output logic              avg_valid,
  output logic [CODE_W-1:0] avg_code,
  output term_mode_e        avg_mode
);
  localparam int LOG_MAX = (LOG_N_PEAK > LOG_N_DELTA) ? LOG_N_PEAK : LOG_N_DELTA;
  localparam int SUM_W   = CODE_W + LOG_MAX;
  localparam int CNT_W   = LOG_MAX + 1;
  localparam logic [CNT_W-1:0] LAST_P = CNT_W'((1 << LOG_N_PEAK) - 1);
  localparam logic [CNT_W-1:0] LAST_D = CNT_W'((1 << LOG_N_DELTA) - 1);

  logic [SUM_W-1:0]  sum_q;
  logic [SUM_W-1:0]  sum_next;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_last;
  logic [CODE_W-1:0] mean;

  always_comb begin
    sum_next = sum_q + SUM_W'(conv_code);
    cnt_last = (burst_mode == TM_DELTA) ? LAST_D : LAST_P;
    mean     = (burst_mode == TM_DELTA) ? CODE_W'(sum_next >> LOG_N_DELTA)
                                        : CODE_W'(sum_next >> LOG_N_PEAK);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sum_q     <= '0;
      cnt_q     <= '0;
      avg_valid <= 1'b0;
      avg_code  <= '0;
      avg_mode  <= TM_PEAK;
    end else begin
      avg_valid <= 1'b0;
      if (conv_valid) begin
        if (cnt_q == cnt_last) begin
          avg_valid <= 1'b1;
          avg_code  <= mean;
          avg_mode  <= burst_mode;
          sum_q     <= '0;
          cnt_q     <= '0;
        end else begin
          sum_q <= sum_next;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_P || cnt_q <= LAST_D); // R2
  AST_AVG_SINGLE: assert property (@(posedge clk) disable iff (rst)
    avg_valid |=> !avg_valid); // R3
endmodule

// File: rtl/cdd_judge.sv
module cdd_judge
  import cdd_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter int HOLD_W    = 24,
  parameter int THR_PEAK  = 5,
  parameter int THR_DELTA = 24,
  parameter int WIN_LO    = 2000,
  parameter int WIN_HI    = 4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick,
  input  logic [HOLD_W-1:0] holdoff_ticks,
  input  logic              avg_valid,
  input  logic [CODE_W-1:0] avg_code,
  input  term_mode_e        avg_mode,
  output logic              sample_valid,
  output logic [CODE_W-1:0] sample_code,
  output logic              term
);
  localparam logic [CODE_W-1:0] LO_C  = CODE_W'(WIN_LO);
  localparam logic [CODE_W-1:0] HI_C  = CODE_W'(WIN_HI);
  localparam logic [CODE_W-1:0] THR_P = CODE_W'(THR_PEAK);
  localparam logic [CODE_W-1:0] THR_D = CODE_W'(THR_DELTA);

  logic [HOLD_W-1:0] hold_cnt;
  logic              hold_active;
  logic [CODE_W-1:0] peak;
  logic              peak_ok;
  logic              fired;
  logic              in_win;
  logic [CODE_W-1:0] thr;
  logic              drop_hit;

  always_comb begin
    hold_active = hold_cnt < holdoff_ticks;
    in_win      = (avg_code > LO_C) && (avg_code < HI_C);
    thr         = (avg_mode == TM_DELTA) ? THR_D : THR_P;
    drop_hit    = peak_ok && (peak >= avg_code) && ((peak - avg_code) >= thr);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hold_cnt <= '0;
    end else if (tick && hold_active) begin
      hold_cnt <= hold_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      peak         <= '0;
      peak_ok      <= 1'b0;
      fired        <= 1'b0;
      sample_valid <= 1'b0;
      sample_code  <= '0;
      term         <= 1'b0;
    end else begin
      sample_valid <= avg_valid;
      term         <= 1'b0;
      if (avg_valid) begin
        sample_code <= avg_code;
        if (in_win && !hold_active) begin
          if (drop_hit && !fired) begin
            term  <= 1'b1;
            fired <= 1'b1;
          end
          if (!peak_ok || avg_code > peak) begin
            peak    <= avg_code;
            peak_ok <= 1'b1;
          end
        end
      end
    end
  end

  AST_TERM_WITH_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    term |-> sample_valid); // R4
  AST_TERM_WINDOW: assert property (@(posedge clk) disable iff (rst)
    term |-> (sample_code > LO_C && sample_code < HI_C)); // R6
  AST_NO_TERM_HOLD: assert property (@(posedge clk) disable iff (rst)
    term |-> !$past(hold_active)); // R7
  AST_TERM_ONCE: assert property (@(posedge clk) disable iff (rst)
    term |-> !$past(fired)); // R8
  AST_PEAK_MONO: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr) && !$past(rst)) |-> peak >= $past(peak)); // R6
  AST_CLR_FORGETS: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (!peak_ok && !fired)); // R9
endmodule

// File: rtl/cell_drop_detector.sv
module cell_drop_detector
  import cdd_pkg::*;
#(
  parameter int CODE_W         = 12,
  parameter int HOLD_W         = 24,
  parameter int INTERVAL_TICKS = 298246,
  parameter int SPACE_TICKS    = 1,
  parameter int LOG_N_PEAK     = 5,
  parameter int LOG_N_DELTA    = 4,
  parameter int THR_PEAK       = 5,
  parameter int THR_DELTA      = 24,
  parameter int WIN_LO         = 2000,
  parameter int WIN_HI         = 4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick,
  input  logic              mode,
  input  logic [HOLD_W-1:0] holdoff_ticks,
  output logic              conv_req,
  input  logic              conv_valid,
  input  logic [CODE_W-1:0] conv_code,
  output logic              sample_valid,
  output logic [CODE_W-1:0] sample_code,
  output logic              term
);
  term_mode_e        burst_mode;
  logic              avg_valid;
  logic [CODE_W-1:0] avg_code;
  term_mode_e        avg_mode;

  cdd_pacer #(
    .INTERVAL_TICKS(INTERVAL_TICKS), .SPACE_TICKS(SPACE_TICKS),
    .LOG_N_PEAK(LOG_N_PEAK), .LOG_N_DELTA(LOG_N_DELTA)
  ) u_pacer (
    .clk(clk), .rst(rst), .clr(clr), .tick(tick), .mode(mode),
    .conv_req(conv_req), .burst_mode(burst_mode)
  );

  cdd_accum #(
    .CODE_W(CODE_W), .LOG_N_PEAK(LOG_N_PEAK), .LOG_N_DELTA(LOG_N_DELTA)
  ) u_accum (
    .clk(clk), .rst(rst), .clr(clr), .conv_valid(conv_valid),
    .conv_code(conv_code), .burst_mode(burst_mode),
    .avg_valid(avg_valid), .avg_code(avg_code), .avg_mode(avg_mode)
  );

  cdd_judge #(
    .CODE_W(CODE_W), .HOLD_W(HOLD_W), .THR_PEAK(THR_PEAK),
    .THR_DELTA(THR_DELTA), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_judge (
    .clk(clk), .rst(rst), .clr(clr), .tick(tick),
    .holdoff_ticks(holdoff_ticks), .avg_valid(avg_valid),
    .avg_code(avg_code), .avg_mode(avg_mode),
    .sample_valid(sample_valid), .sample_code(sample_code), .term(term)
  );

  AST_OUT_RESET: assert property (@(posedge clk)
    $past(rst) |-> (!conv_req && !sample_valid && !term)); // R10
endmodule

// File: tb/test_cell_drop_detector.sv
`timescale 1ns/1ps
module test_cell_drop_detector;
  localparam int IVT = 120;
  localparam int SPT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        tick = 1'b0;
  logic        mode = 1'b0;
  logic [23:0] holdoff_ticks = '0;
  logic        conv_req;
  logic        conv_valid = 1'b0;
  logic [11:0] conv_code = '0;
  logic        sample_valid;
  logic [11:0] sample_code;
  logic        term;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ticks_since = 0;
  int next_base = 3000;
  int next_noise = 0;
  int m_sum = 0, m_cnt = 0, exp_avg = 0, last_valid_cyc = 0;
  int req_cnt = 0, last_req_cyc = 0;
  bit sp_bad = 0;
  int m_peak = 0;
  bit m_ok = 0, m_fired = 0;

  always #5 clk = ~clk;

  cell_drop_detector #(.INTERVAL_TICKS(IVT), .SPACE_TICKS(SPT)) i_cell_drop_detector (
    .clk(clk), .rst(rst), .clr(clr), .tick(tick), .mode(mode),
    .holdoff_ticks(holdoff_ticks), .conv_req(conv_req), .conv_valid(conv_valid),
    .conv_code(conv_code), .sample_valid(sample_valid),
    .sample_code(sample_code), .term(term)
  );

  function automatic int burst_len(input bit md);
    return md ? 16 : 32;
  endfunction

  function automatic int burst_shift(input bit md);
    return md ? 4 : 5;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // timebase, cycle counter and converter model, all on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      tick = cyc[0];
      if (tick) ticks_since++;
      conv_valid = 1'b0;
      if (!rst && conv_req) begin
        if (m_cnt == 0) begin
          req_cnt = 0;
          sp_bad  = 0;
        end else if (cyc - last_req_cyc != 2 * SPT) begin
          sp_bad = 1;
        end
        last_req_cyc = cyc;
        req_cnt++;
        conv_code  = 12'(next_base + int'($urandom % (next_noise + 1)));
        conv_valid = 1'b1;
        m_sum += int'(conv_code);
        m_cnt++;
        if (m_cnt == burst_len(mode)) begin
          exp_avg = m_sum >> burst_shift(mode);
          last_valid_cyc = cyc;
          m_sum = 0;
          m_cnt = 0;
        end
      end
    end
  end

  task automatic start_cycle(input bit md, input int hold);
    @(negedge clk);
    #1;
    mode = md;
    holdoff_ticks = 24'(hold);
    clr = 1'b1;
    ticks_since = 0;
    m_sum = 0;
    m_cnt = 0;
    m_ok = 0;
    m_fired = 0;
    @(negedge clk);
    #1;
    clr = 1'b0;
  endtask

  task automatic take_sample(input int base, input int noise, input string req);
    int waited = 0;
    bit exp_t, in_win, hold;
    next_base = base;
    next_noise = noise;
    do begin
      @(negedge clk);
      #1;
      waited++;
    end while (!sample_valid && waited < 2000);
    if (!sample_valid) begin
      check(0, "R3 sample never arrived", 0, 1);
      return;
    end
    check(req_cnt == burst_len(mode) && !sp_bad, "R1 burst requests", req_cnt, burst_len(mode));
    check(int'(sample_code) == exp_avg, "R2 averaged code", int'(sample_code), exp_avg);
    check(cyc == last_valid_cyc + 2, "R3 sample latency", cyc - last_valid_cyc, 2);
    in_win = exp_avg > 2000 && exp_avg < 4000;
    hold   = ticks_since < int'(holdoff_ticks);
    exp_t  = in_win && !hold && m_ok && !m_fired && (m_peak - exp_avg >= (mode ? 24 : 5));
    if (exp_t) m_fired = 1;
    if (in_win && !hold && (!m_ok || exp_avg > m_peak)) begin
      m_peak = exp_avg;
      m_ok = 1;
    end
    check(term == exp_t, req, int'(term), int'(exp_t));
    @(negedge clk);
    #1;
    check(!term && !sample_valid, "R3 single-cycle strobes", int'(term), 0);
  endtask

  initial begin
    int b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check(!conv_req && !sample_valid && !term, "R10 outputs in reset", int'(term), 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(!conv_req && !sample_valid && !term, "R10 outputs after reset", int'(term), 0);

    // peak mode thresholds and single pulse
    start_cycle(1'b0, 0);
    take_sample(3000, 0, "R4 first sample sets peak");
    take_sample(3010, 0, "R4 rising sample");
    take_sample(3006, 0, "R4 drop of 4 ignored");
    take_sample(3005, 0, "R4 drop of 5 terminates");
    take_sample(2900, 0, "R8 no second pulse");

    // delta mode thresholds
    start_cycle(1'b1, 0);
    take_sample(3000, 0, "R5 first sample");
    take_sample(2977, 0, "R5 drop of 23 ignored");
    take_sample(2976, 0, "R5 drop of 24 terminates");

    // window
    start_cycle(1'b0, 0);
    take_sample(3000, 0, "R6 in-window peak");
    take_sample(4050, 0, "R6 high sample ignored");
    take_sample(2996, 0, "R6 peak not raised by high sample");
    take_sample(1990, 0, "R6 low sample ignored");
    take_sample(2995, 0, "R6 in-window drop terminates");

    // hold-off
    start_cycle(1'b0, 300);
    take_sample(3500, 0, "R7 sample in hold-off");
    take_sample(3000, 0, "R7 first sample after hold-off");
    take_sample(2996, 0, "R7 hold-off sample did not set peak");
    take_sample(2995, 0, "R7 drop after hold-off terminates");

    // clear forgets old peak
    start_cycle(1'b0, 0);
    take_sample(2800, 0, "R9 old peak forgotten");
    take_sample(2790, 0, "R9 new peak in use");

    // random walks in both modes with ripple on the codes
    for (int md = 0; md < 2; md++) begin
      start_cycle(md[0], 0);
      b = 2300;
      for (int i = 0; i < 14; i++) begin
        if (i < 8) b += int'($urandom % 25);
        else b -= int'($urandom % 9);
        take_sample(b, 7, md ? "R5 random walk" : "R4 random walk");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule